// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transmitter

This block serialises one byte at a time onto an idle-high line, paced by a free-running bit-rate tick that arrives from outside. Software, or a neighbouring controller, writes a holding register; when the current frame's stop bit has ended, the held byte and its configuration are captured into a shift register. The next frame then starts on the next tick. Because a buffer-empty status is provided, a second byte can be queued while a frame is on the line, and frames go out back to back with no idle gap.

Three frame formats are supported. The first is a ten-bit frame with eight payload bits, or with seven payload bits and a parity bit in the top position. The second is an eleven-bit frame whose ninth bit comes from a control bit that clears itself. The third is an eleven-bit frame whose ninth bit is either parity over all eight data bits or, with parity off, the control bit. A sticky completion flag and a one-cycle interrupt pulse report each frame. They fire either as the stop bit begins or a chosen number of bit times later.

Top module: `ninebit_sertx`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `buf_empty` is 1, and `tx_done`, `tx_irq` and `ninth_q` are 0.
- R2: A write to the holding register while the line is idle starts a frame on the next `bit_tick`. The start bit (0) appears after that tick's clock edge, `buf_empty` returns to 1 at the same edge, and the line changes only on `bit_tick` cycles.
- R3: With `fmt_sel`=2'b00 and parity disabled, the frame is a start bit, then `wr_data` bits 0..7 LSB first, then one stop bit (1), with one bit per tick: 10 bits in total.
- R4: With `fmt_sel`=2'b00 and `par_en`=1, the eighth data position carries parity over data bits 0..6. This parity is even when `par_odd`=0, so that the seven bits plus parity hold an even number of ones, and odd when `par_odd`=1.
- R5: With `fmt_sel`=2'b01, the frame has 11 bits: start, data bits 0..7, the ninth-bit control value, and stop. `par_en` has no effect in this format.
- R6: With `fmt_sel`=2'b10 (and 2'b11, which behaves the same), the frame has 11 bits. The ninth position carries parity over all eight data bits when `par_en`=1 (even or odd as in R4), and the ninth-bit control value otherwise.
- R7: The ninth-bit control value, visible on `ninth_q`, returns to 0 at the edge where a frame is captured into the shift register.
- R8: A byte written while a frame is being sent is held until that frame's stop bit has lasted one full bit time. Its start bit then follows immediately, and the frame in flight is not altered.
- R9: With `dly_sel`=0, `tx_done` becomes 1 and `tx_irq` pulses for exactly one cycle at the same edge where the stop bit appears on `txd`.
- R10: With `dly_sel` equal to 1, 2 or 3, the flag and the pulse are instead raised 1, 3 or 7 ticks after the stop bit begins.
- R11: `tx_done` stays at 1 until `done_clr` is pulsed, and it reads 0 on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time, free running |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to send |
| ninth_wr | input | 1 | Write strobe for the ninth-bit control value |
| ninth_val | input | 1 | Ninth-bit control value |
| fmt_sel | input | 2 | Frame format: 00 ten-bit, 01 ninth-bit, 10/11 ninth-bit with optional parity |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| dly_sel | input | 2 | Completion delay: 0, 1, 3 or 7 bit times |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line, idle high |
| tx_done | output | 1 | Sticky completion flag |
| tx_irq | output | 1 | One-cycle completion pulse |
| buf_empty | output | 1 | Holding register can accept a byte |
| ninth_q | output | 1 | Current ninth-bit control value |

## Verification
On every cycle, the assertions check that the line moves only on tick cycles, that each frame opens low and closes high, and that the holding register empties and the ninth bit clears when a frame is captured. They also check that the completion flag holds until cleared, and that the pulse never occurs without the flag or lasts longer than a cycle. Only the bench scenarios can show the bit order and the parity value in each format, the exact tick on which a delayed flag rises, and the seamless hand-over between queued frames. For those, it sweeps formats, parity settings, ninth-bit values and data patterns, and compares whole decoded frames against arithmetic expectations.

// File: rtl/ninebit_sertx_pkg.sv
package ninebit_sertx_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 3;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int DLY_W     = 3;

    typedef enum logic [1:0] {
        FMT_TEN       = 2'b00,
        FMT_NINTH     = 2'b01,
        FMT_NINTH_PAR = 2'b10,
        FMT_ALT       = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [LEN_W-1:0]     len;
    } frame_t;

    // parity over the masked bits; odd selects the complement
    function automatic logic calc_par(input logic [DATA_W-1:0] d,
                                      input logic [DATA_W-1:0] mask,
                                      input logic odd);
        return (^(d & mask)) ^ odd;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d,
                                           input logic ninth,
                                           input fmt_e fmt,
                                           input logic pe,
                                           input logic odd);
        frame_t f;
        logic [DATA_W-1:0] payload;
        logic ext;
        payload = d;
        ext     = ninth;
        f.bits  = '1;
        f.bits[0] = 1'b0;
        if (fmt == FMT_TEN) begin
            if (pe)
                payload[DATA_W-1] = calc_par(d, {1'b0, {(DATA_W-1){1'b1}}}, odd);
            f.bits[DATA_W:1] = payload;
            f.len = LEN_W'(DATA_W + 2);
        end else begin
            if (fmt != FMT_NINTH && pe)
                ext = calc_par(d, '1, odd);
            f.bits[DATA_W:1]   = d;
            f.bits[DATA_W+1]   = ext;
            f.len = LEN_W'(DATA_W + 3);
        end
        return f;
    endfunction

    // bit times of completion delay for each selector code
    function automatic logic [DLY_W-1:0] dly_ticks(input logic [1:0] sel);
        return DLY_W'((4'd1 << sel) - 4'd1);
    endfunction

endpackage

// File: rtl/ninebit_sertx_hold.sv
module ninebit_sertx_hold
    import ninebit_sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              ninth_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // ninth control bit: a fresh write wins over the automatic clear
    always_ff @(posedge clk) begin
        if (rst)
            ninth_q <= 1'b0;
        else if (ninth_wr)
            ninth_q <= ninth_val;
        else if (take)
            ninth_q <= 1'b0;
    end

    assert_ninth_clear_R7: assert property (@(posedge clk) disable iff (rst)
        take && !ninth_wr |=> !ninth_q);

    assert_empty_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        take && !wr_en |=> !hold_full);

endmodule

// File: rtl/ninebit_sertx_framer.sv
module ninebit_sertx_framer
    import ninebit_sertx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic              ninth,
    input  logic [1:0]        fmt_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output frame_t            frame
);

    always_comb begin
        frame = build_frame(data, ninth, fmt_e'(fmt_sel), par_en, par_odd);
    end

endmodule

// File: rtl/ninebit_sertx_shifter.sv
module ninebit_sertx_shifter
    import ninebit_sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_tick,
    input  frame_t nxt,
    input  logic   nxt_valid,
    output logic   take,
    output logic   stop_begin,
    output logic   txd
);

    logic                 active;
    logic [FRAME_MAX-1:0] sr;
    logic [LEN_W-1:0]     left;
    logic                 slot_end;

    // a bit slot closes on every tick while idle or at the end of the stop bit
    assign slot_end   = bit_tick && (!active || left == '0);
    assign take       = slot_end && nxt_valid;
    assign stop_begin = bit_tick && active && left == LEN_W'(1);
    assign txd        = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sr     <= '1;
            left   <= '0;
        end else if (take) begin
            active <= 1'b1;
            sr     <= nxt.bits;
            left   <= nxt.len - LEN_W'(1);
        end else if (slot_end) begin
            active <= 1'b0;
            sr     <= '1;
        end else if (bit_tick && active) begin
            sr     <= {1'b1, sr[FRAME_MAX-1:1]};
            left   <= left - LEN_W'(1);
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

    assert_tick_paced_R2: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(txd));

    assert_stop_high_R8: assert property (@(posedge clk) disable iff (rst)
        active && left == '0 |-> txd);

endmodule

// File: rtl/ninebit_sertx_done.sv
module ninebit_sertx_done
    import ninebit_sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       stop_begin,
    input  logic [1:0] dly_sel,
    input  logic       done_clr,
    output logic       tx_done,
    output logic       tx_irq
);

    logic [DLY_W-1:0] dly_cnt;
    logic             set_now;

    assign set_now = (stop_begin && dly_sel == 2'd0)
                   || (bit_tick && dly_cnt == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            dly_cnt <= '0;
        else if (stop_begin && dly_sel != 2'd0)
            dly_cnt <= dly_ticks(dly_sel);
        else if (bit_tick && dly_cnt != '0)
            dly_cnt <= dly_cnt - DLY_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_done <= 1'b0;
            tx_irq  <= 1'b0;
        end else begin
            tx_irq <= set_now;
            if (set_now)
                tx_done <= 1'b1;
            else if (done_clr)
                tx_done <= 1'b0;
        end
    end

    assert_irq_has_flag_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> tx_done);

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        tx_done && !done_clr |=> tx_done);

    assert_delay_holds_R10: assert property (@(posedge clk) disable iff (rst)
        stop_begin && dly_sel != 2'd0 |=> !tx_irq);

endmodule

// File: rtl/ninebit_sertx.sv
module ninebit_sertx
    import ninebit_sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth_wr,
    input  logic              ninth_val,
    input  logic [1:0]        fmt_sel,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        dly_sel,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done,
    output logic              tx_irq,
    output logic              buf_empty,
    output logic              ninth_q
);

    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              take;
    logic              stop_begin;
    frame_t            frame;

    ninebit_sertx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ninth_wr  (ninth_wr),
        .ninth_val (ninth_val),
        .take      (take),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .ninth_q   (ninth_q)
    );

    ninebit_sertx_framer u_framer (
        .data    (hold_data),
        .ninth   (ninth_q),
        .fmt_sel (fmt_sel),
        .par_en  (par_en),
        .par_odd (par_odd),
        .frame   (frame)
    );

    ninebit_sertx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .nxt        (frame),
        .nxt_valid  (hold_full),
        .take       (take),
        .stop_begin (stop_begin),
        .txd        (txd)
    );

    ninebit_sertx_done u_done (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .stop_begin (stop_begin),
        .dly_sel    (dly_sel),
        .done_clr   (done_clr),
        .tx_done    (tx_done),
        .tx_irq     (tx_irq)
    );

    assign buf_empty = !hold_full;

endmodule

// File: tb/ninebit_sertx_test.sv
`timescale 1ns/1ps
module ninebit_sertx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ninth_wr = 1'b0;
    logic       ninth_val = 1'b0;
    logic [1:0] fmt_sel = '0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] dly_sel = '0;
    logic       done_clr = 1'b0;
    logic       txd, tx_done, tx_irq, buf_empty, ninth_q;

    int total = 0;
    int bad = 0;
    logic [1:0] phase = '0;

    always #2 clk = ~clk;

    ninebit_sertx uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_data(wr_data), .ninth_wr(ninth_wr), .ninth_val(ninth_val),
        .fmt_sel(fmt_sel), .par_en(par_en), .par_odd(par_odd),
        .dly_sel(dly_sel), .done_clr(done_clr), .txd(txd),
        .tx_done(tx_done), .tx_irq(tx_irq), .buf_empty(buf_empty),
        .ninth_q(ninth_q)
    );

    // one tick every four clocks, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            phase    <= '0;
            bit_tick <= 1'b0;
        end else begin
            phase    <= phase + 2'd1;
            bit_tick <= (phase == 2'd3);
        end
    end

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] expect_frame(input logic [1:0] fmt,
            input logic pe, input logic po, input logic nin, input logic [7:0] d);
        logic [10:0] f;
        f = '1;
        f[0] = 1'b0;
        f[8:1] = d;
        if (fmt == 2'b00) begin
            if (pe) f[8] = (^d[6:0]) ^ po;
        end else begin
            f[9] = nin;
            if (fmt != 2'b01 && pe) f[9] = (^d) ^ po;
        end
        return f;
    endfunction

    task automatic pulse_clr();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic set_ninth(input logic v);
        ninth_wr = 1'b1; ninth_val = v;
        @(negedge clk);
        ninth_wr = 1'b0; ninth_val = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start();
        int t;
        t = 0;
        while (txd !== 1'b0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(t < 400, "R2 start bit", 32'(t), 32'd0);
    endtask

    // samples bits 1..n-1; returns at the negedge just after the stop bit appeared
    task automatic grab(input int n, output logic [10:0] got);
        got = '1;
        got[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (4) @(negedge clk);
            got[i] = txd;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] got;
        logic [10:0] exp;
        int n;
        string tag;

        repeat (5) @(negedge clk);
        chk(txd === 1'b1, "R1 txd", 32'(txd), 32'd1);
        chk(buf_empty === 1'b1, "R1 buf_empty", 32'(buf_empty), 32'd1);
        chk(tx_done === 1'b0 && tx_irq === 1'b0, "R1 flags", {tx_done, tx_irq}, 32'd0);
        chk(ninth_q === 1'b0, "R1 ninth", 32'(ninth_q), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // sweep of formats, parity settings, ninth bit and data
        for (int fm = 0; fm < 3; fm++)
            for (int pe = 0; pe < 2; pe++)
                for (int po = 0; po < 2; po++)
                    for (int nb = 0; nb < 2; nb++)
                        for (int k = 0; k < 10; k++) begin
                            logic [7:0] d;
                            d = (k == 8) ? 8'h00 : (k == 9) ? 8'hFF : 8'((k * 37 + 5) & 255);
                            fmt_sel = 2'(fm); par_en = 1'(pe); par_odd = 1'(po);
                            dly_sel = 2'd0;
                            pulse_clr();
                            set_ninth(1'(nb));
                            write_byte(d);
                            wait_start();
                            chk(buf_empty === 1'b1, "R2 buffer emptied", 32'(buf_empty), 32'd1);
                            chk(ninth_q === 1'b0, "R7 ninth cleared", 32'(ninth_q), 32'd0);
                            n = (fm == 0) ? 10 : 11;
                            exp = expect_frame(2'(fm), 1'(pe), 1'(po), 1'(nb), d);
                            grab(n, got);
                            if (fm == 0) tag = pe ? "R4 frame" : "R3 frame";
                            else if (fm == 1) tag = "R5 frame";
                            else tag = "R6 frame";
                            chk(got == exp, tag, 32'(got), 32'(exp));
                            chk(tx_done === 1'b1 && tx_irq === 1'b1, "R9 flag at stop",
                                {tx_done, tx_irq}, 32'd3);
                            @(negedge clk);
                            chk(tx_irq === 1'b0, "R9 single pulse", 32'(tx_irq), 32'd0);
                            repeat (4) @(negedge clk);
                        end

        // code 2'b11 behaves as the parity-capable eleven-bit format
        fmt_sel = 2'b11; par_en = 1'b1; par_odd = 1'b1;
        pulse_clr();
        write_byte(8'hA7);
        wait_start();
        grab(11, got);
        exp = expect_frame(2'b10, 1'b1, 1'b1, 1'b0, 8'hA7);
        chk(got == exp, "R6 alternate code", 32'(got), 32'(exp));
        repeat (6) @(negedge clk);

        // delayed completion flag
        fmt_sel = 2'b00; par_en = 1'b0;
        for (int s = 1; s < 4; s++) begin
            int dl;
            dl = (1 << s) - 1;
            dly_sel = 2'(s);
            pulse_clr();
            write_byte(8'h3C);
            wait_start();
            grab(10, got);
            chk(tx_done === 1'b0, "R10 not at stop", 32'(tx_done), 32'd0);
            repeat (4 * dl - 1) @(negedge clk);
            chk(tx_done === 1'b0, "R10 one cycle early", 32'(tx_done), 32'd0);
            @(negedge clk);
            chk(tx_done === 1'b1 && tx_irq === 1'b1, "R10 flag after delay",
                {tx_done, tx_irq}, 32'd3);
            repeat (8) @(negedge clk);
        end
        dly_sel = 2'd0;

        // sticky flag and clear
        repeat (40) @(negedge clk);
        chk(tx_done === 1'b1, "R11 flag held", 32'(tx_done), 32'd1);
        pulse_clr();
        chk(tx_done === 1'b0, "R11 flag cleared", 32'(tx_done), 32'd0);

        // back-to-back frames
        fmt_sel = 2'b01; par_en = 1'b0;
        set_ninth(1'b1);
        write_byte(8'h5A);
        wait_start();
        set_ninth(1'b0);
        write_byte(8'hC3);
        grab(11, got);
        exp = expect_frame(2'b01, 1'b0, 1'b0, 1'b1, 8'h5A);
        chk(got == exp, "R8 first frame intact", 32'(got), 32'(exp));
        chk(buf_empty === 1'b0, "R8 held during stop", 32'(buf_empty), 32'd0);
        repeat (4) @(negedge clk);
        chk(txd === 1'b0, "R8 next start follows stop", 32'(txd), 32'd0);
        grab(11, got);
        exp = expect_frame(2'b01, 1'b0, 1'b0, 1'b0, 8'hC3);
        chk(got == exp, "R8 second frame", 32'(got), 32'(exp));

        repeat (8) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule